// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is a serial peripheral interface master that software drives through a small 16-bit register bus. One command moves between 1 and 32 bits. The outgoing word is held in two 16-bit halves and leaves most significant bit first, starting at bit 31, so software left-aligns short words. When a command asks for receive data, the bits coming back on the input line are gathered into a 32-bit receive word. That word is right-justified, so a short transfer lands in the low bits.

Every command carries its own length, its own target device index and its own mode: transmit only, or full duplex. The serial clock is the bus clock divided by a fixed even ratio. It idles low. Data changes on the falling edge and is sampled on the rising edge. A chip-select line goes low half a serial period before the first rising edge and comes back high half a period after the last falling edge. Completion shows up in two status flags and as a one-cycle interrupt pulse that a mask bit can suppress.

Register map (word index on `bus_addr`): 0 setup, 1 select-enable, 2 command, 3 status, 4 transmit high, 5 transmit low, 6 receive high, 7 receive low. Reads of the command register return zero.

Top module: `spim_top`

## Requirements
- R1: After reset the setup register reads 0, the select-enable register reads 0x0001, the status register reads 0, every `cs_n` line is high, `sclk` is low and `irq` is low.
- R2: A command write to index 2 with bit 8 (transmit only) or bit 9 (full duplex) set starts a transfer of (bits[4:0] + 1) bits. The bits go out on `mosi` in order from bit 31 of {transmit high, transmit low} downward, and exactly that many rising `sclk` edges occur.
- R3: `sclk` idles low. `mosi` changes only while `sclk` is low. Each `sclk` high or low phase lasts CLK_DIV/2 bus clocks.
- R4: Command bits[7:5] select the device index. Line `cs_n[d]` goes low during the transfer only when select-enable bit d is set. At most one line is low at a time. A command whose index is NUM_CS or more is ignored.
- R5: In full-duplex mode the `miso` bit sampled on each rising edge is shifted in from the bottom, so an n-bit transfer leaves its first sampled bit at receive-word bit n-1 and its last at bit 0. Receive high (index 6) holds bits 31:16 and receive low (index 7) holds bits 15:0.
- R6: Status bit 0 sets when any transfer completes. Status bit 1 sets only when a full-duplex transfer completes. Both clear when the status register is read and when a new transfer starts.
- R7: A command write while a transfer is in progress is ignored: the running transfer keeps its length, device and mode, and no second transfer follows.
- R8: `irq` pulses high for one clock when a transfer completes. Setup bit 1 suppresses the pulse for transmit-only transfers and setup bit 2 suppresses it for full-duplex transfers.
- R9: While setup bit 0 (clock enable) is clear, command writes start nothing: no status flag, no chip select and no `sclk` edge appears.
- R10: The chip select falls CLK_DIV/2 clocks before the first rising `sclk` edge and rises CLK_DIV/2 clocks after the last falling `sclk` edge, with `sclk` low at both moments.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | NUM_CS | Active-low chip selects |
| irq | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach from the ports is a command arriving in the middle of a running transfer, because it must land within the short busy window that the serial clock ratio sets. The bench issues a second command a few cycles after the first one, with a different device, length and mode. It then checks that the bit count, the chip-select line seen, the status flags and the interrupt count all match the first command alone. A bench slave model answers on `miso` from a known word, so both shift directions are checked under random lengths from 1 to 32 and random masks, together with directed cases at lengths 1 and 32, a disabled select line and a status flag cleared by a new start.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int unsigned DW = 16;
  localparam int unsigned AW = 3;

  localparam logic [AW-1:0] A_SETUP = 3'd0;
  localparam logic [AW-1:0] A_CSEN  = 3'd1;
  localparam logic [AW-1:0] A_CMD   = 3'd2;
  localparam logic [AW-1:0] A_STAT  = 3'd3;
  localparam logic [AW-1:0] A_TXH   = 3'd4;
  localparam logic [AW-1:0] A_TXL   = 3'd5;
  localparam logic [AW-1:0] A_RXH   = 3'd6;
  localparam logic [AW-1:0] A_RXL   = 3'd7;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned LEN_W  = 5;
  localparam int unsigned DEV_W  = 3;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_HIGH,
    PH_LOW,
    PH_TAIL
  } phase_e;

  typedef struct packed {
    logic [LEN_W-1:0] len_m1;
    logic [DEV_W-1:0] dev;
    logic             duplex;
  } xfer_cmd_t;
endpackage

// File: rtl/spim_rstsync.sv
module spim_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/spim_clkdiv.sv
module spim_clkdiv #(
  parameter int unsigned HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic en,
  output logic tick
);
  localparam int unsigned CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = run && en && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (!run || tick) cnt_d = '0;
    else if (en)      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/spim_engine.sv
module spim_engine
  import spim_pkg::*;
#(
  parameter int unsigned NUM_CS = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  xfer_cmd_t         cmd,
  input  logic [WORD_W-1:0] tx_word,
  input  logic              tick,
  input  logic              miso,
  input  logic [NUM_CS-1:0] cs_en,
  output logic              sclk,
  output logic              mosi,
  output logic [NUM_CS-1:0] cs_n,
  output logic              busy,
  output logic              done,
  output logic              done_duplex,
  output logic [WORD_W-1:0] rx_word
);
  phase_e             ph_q, ph_d;
  logic [WORD_W-1:0]  sh_q, sh_d;
  logic [WORD_W-1:0]  rx_q, rx_d;
  logic [LEN_W-1:0]   left_q, left_d;
  logic [DEV_W-1:0]   dev_q, dev_d;
  logic               dup_q, dup_d;
  logic               sclk_q, sclk_d;
  logic               done_q, done_d;
  logic [NUM_CS-1:0]  csn_q, csn_d;

  always_comb begin
    ph_d   = ph_q;
    sh_d   = sh_q;
    rx_d   = rx_q;
    left_d = left_q;
    dev_d  = dev_q;
    dup_d  = dup_q;
    sclk_d = sclk_q;
    done_d = 1'b0;
    unique case (ph_q)
      PH_IDLE: if (start) begin
        ph_d   = PH_SETUP;
        sh_d   = tx_word;
        rx_d   = '0;
        left_d = cmd.len_m1;
        dev_d  = cmd.dev;
        dup_d  = cmd.duplex;
      end
      PH_SETUP, PH_LOW: if (tick) begin
        sclk_d = 1'b1;
        rx_d   = {rx_q[WORD_W-2:0], miso};
        ph_d   = PH_HIGH;
      end
      PH_HIGH: if (tick) begin
        sclk_d = 1'b0;
        if (left_q == '0) begin
          ph_d = PH_TAIL;
        end else begin
          left_d = left_q - 1'b1;
          sh_d   = {sh_q[WORD_W-2:0], 1'b0};
          ph_d   = PH_LOW;
        end
      end
      PH_TAIL: if (tick) begin
        ph_d   = PH_IDLE;
        done_d = 1'b1;
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    always_comb csn_d[i] = !((ph_d != PH_IDLE) && (dev_d == DEV_W'(i)) && cs_en[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      sh_q   <= '0;
      rx_q   <= '0;
      left_q <= '0;
      dev_q  <= '0;
      dup_q  <= 1'b0;
      sclk_q <= 1'b0;
      done_q <= 1'b0;
      csn_q  <= '1;
    end else begin
      ph_q   <= ph_d;
      sh_q   <= sh_d;
      rx_q   <= rx_d;
      left_q <= left_d;
      dev_q  <= dev_d;
      dup_q  <= dup_d;
      sclk_q <= sclk_d;
      done_q <= done_d;
      csn_q  <= csn_d;
    end
  end

  assign sclk        = sclk_q;
  assign mosi        = sh_q[WORD_W-1];
  assign cs_n        = csn_q;
  assign busy        = (ph_q != PH_IDLE);
  assign done        = done_q;
  assign done_duplex = done_q && dup_q;
  assign rx_word     = rx_q;
endmodule

// File: rtl/spim_regs.sv
module spim_regs
  import spim_pkg::*;
#(
  parameter int unsigned NUM_CS = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              busy,
  input  logic              done,
  input  logic              done_duplex,
  input  logic [WORD_W-1:0] rx_word,
  output logic              start,
  output xfer_cmd_t         cmd,
  output logic [WORD_W-1:0] tx_word,
  output logic              clk_en,
  output logic [NUM_CS-1:0] cs_en,
  output logic              irq
);
  logic [2:0]        setup_q, setup_d;
  logic [NUM_CS-1:0] csen_q, csen_d;
  logic [DW-1:0]     txh_q, txh_d, txl_q, txl_d;
  logic [DW-1:0]     rxh_q, rxh_d, rxl_q, rxl_d;
  logic              wend_q, wend_d, rend_q, rend_d;
  logic              irq_q, irq_d;

  logic wr_hit, rd_stat, cmd_go, dev_ok;
  logic unused_wdata;

  assign unused_wdata = ^bus_wdata[DW-1:10];

  assign wr_hit  = bus_sel && bus_wr;
  assign rd_stat = bus_sel && !bus_wr && (bus_addr == A_STAT);

  assign cmd.len_m1 = bus_wdata[LEN_W-1:0];
  assign cmd.dev    = bus_wdata[LEN_W+DEV_W-1:LEN_W];
  assign cmd.duplex = bus_wdata[9];

  assign dev_ok = int'(cmd.dev) < int'(NUM_CS);
  assign cmd_go = bus_wdata[8] || bus_wdata[9];
  assign start  = wr_hit && (bus_addr == A_CMD) && cmd_go && dev_ok
                  && !busy && setup_q[0];

  always_comb begin
    setup_d = setup_q;
    csen_d  = csen_q;
    txh_d   = txh_q;
    txl_d   = txl_q;
    if (wr_hit) begin
      unique case (bus_addr)
        A_SETUP: setup_d = bus_wdata[2:0];
        A_CSEN:  csen_d  = bus_wdata[NUM_CS-1:0];
        A_TXH:   txh_d   = bus_wdata;
        A_TXL:   txl_d   = bus_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    rxh_d  = rxh_q;
    rxl_d  = rxl_q;
    wend_d = wend_q;
    rend_d = rend_q;
    if (start || rd_stat) begin
      wend_d = 1'b0;
      rend_d = 1'b0;
    end
    if (done) begin
      wend_d = 1'b1;
      if (done_duplex) begin
        rend_d = 1'b1;
        rxh_d  = rx_word[WORD_W-1:DW];
        rxl_d  = rx_word[DW-1:0];
      end
    end
    irq_d = done && !(done_duplex ? setup_q[2] : setup_q[1]);
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      A_SETUP: bus_rdata = DW'(setup_q);
      A_CSEN:  bus_rdata = DW'(csen_q);
      A_STAT:  bus_rdata = DW'({rend_q, wend_q});
      A_TXH:   bus_rdata = txh_q;
      A_TXL:   bus_rdata = txl_q;
      A_RXH:   bus_rdata = rxh_q;
      A_RXL:   bus_rdata = rxl_q;
      default: bus_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      setup_q <= '0;
      csen_q  <= NUM_CS'(1);
      txh_q   <= '0;
      txl_q   <= '0;
      rxh_q   <= '0;
      rxl_q   <= '0;
      wend_q  <= 1'b0;
      rend_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      setup_q <= setup_d;
      csen_q  <= csen_d;
      txh_q   <= txh_d;
      txl_q   <= txl_d;
      rxh_q   <= rxh_d;
      rxl_q   <= rxl_d;
      wend_q  <= wend_d;
      rend_q  <= rend_d;
      irq_q   <= irq_d;
    end
  end

  assign tx_word = {txh_q, txl_q};
  assign clk_en  = setup_q[0];
  assign cs_en   = csen_q;
  assign irq     = irq_q;
endmodule

// File: rtl/spim_top.sv
module spim_top
  import spim_pkg::*;
#(
  parameter int unsigned NUM_CS  = 5,
  parameter int unsigned CLK_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [2:0]        bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_CS-1:0] cs_n,
  output logic              irq
);
  localparam int unsigned HALF = CLK_DIV / 2;

  logic              rst_n_int;
  logic              start, busy, done, done_duplex, tick, clk_en;
  xfer_cmd_t         cmd;
  logic [WORD_W-1:0] tx_word, rx_word;
  logic [NUM_CS-1:0] cs_en;

  spim_rstsync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  spim_regs #(.NUM_CS(NUM_CS)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .busy        (busy),
    .done        (done),
    .done_duplex (done_duplex),
    .rx_word     (rx_word),
    .start       (start),
    .cmd         (cmd),
    .tx_word     (tx_word),
    .clk_en      (clk_en),
    .cs_en       (cs_en),
    .irq         (irq)
  );

  spim_clkdiv #(.HALF(HALF)) u_div (
    .clk   (clk),
    .rst_n (rst_n_int),
    .run   (busy),
    .en    (clk_en),
    .tick  (tick)
  );

  spim_engine #(.NUM_CS(NUM_CS)) u_eng (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .start       (start),
    .cmd         (cmd),
    .tx_word     (tx_word),
    .tick        (tick),
    .miso        (miso),
    .cs_en       (cs_en),
    .sclk        (sclk),
    .mosi        (mosi),
    .cs_n        (cs_n),
    .busy        (busy),
    .done        (done),
    .done_duplex (done_duplex),
    .rx_word     (rx_word)
  );
endmodule

// File: rtl/spim_checker.sv
module spim_checker #(
  parameter int unsigned NUM_CS  = 5,
  parameter int unsigned CLK_DIV = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sclk,
  input logic              mosi,
  input logic [NUM_CS-1:0] cs_n,
  input logic              irq
);
  AST_CS_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~cs_n) <= 1); // R4

  AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi)); // R3

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R8

  AST_CS_FALL_SCLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(&cs_n) |-> !sclk); // R10

  AST_CS_RISE_SCLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(&cs_n) |-> !sclk); // R10

  if (CLK_DIV >= 4) begin : g_min_high
    AST_SCLK_HIGH_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sclk) |=> sclk); // R3
  end
endmodule

bind spim_top spim_checker #(.NUM_CS(NUM_CS), .CLK_DIV(CLK_DIV)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .sclk  (sclk),
  .mosi  (mosi),
  .cs_n  (cs_n),
  .irq   (irq)
);

// File: tb/tb_spim_top.sv
module tb_spim_top;
  localparam int NCS  = 5;
  localparam int DIV  = 4;
  localparam int HALF = DIV / 2;

  logic            clk, rst_n;
  logic            bus_sel, bus_wr;
  logic [2:0]      bus_addr;
  logic [15:0]     bus_wdata, bus_rdata;
  logic            sclk, mosi, miso, irq;
  logic [NCS-1:0]  cs_n;

  int tests = 0, fails = 0;

  spim_top #(.NUM_CS(NCS), .CLK_DIV(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n), .irq(irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // slave model and monitor, all on the falling bus clock edge
  logic [31:0]    slave_word = 32'h0;
  int             xfer_id = 0;
  int             seen_id = 0;
  int             cyc = 0, mon_bits = 0, fall_cnt = 0, irq_cnt = 0;
  int             t_csf = 0, t_rise = 0, t_fall = 0, t_csr = 0;
  logic           wait_first = 1'b0, p_any = 1'b0, p_sclk = 1'b0;
  logic [31:0]    mon_mosi = 32'h0;
  logic [NCS-1:0] cs_seen = '0;
  logic           any_cs;

  assign any_cs = ~&cs_n;
  assign miso   = (fall_cnt < 32) ? slave_word[31 - fall_cnt] : 1'b0;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (xfer_id != seen_id) begin
      seen_id = xfer_id; mon_bits = 0; mon_mosi = 0; cs_seen = '0;
      fall_cnt = 0; wait_first = 1'b1;
    end
    if (any_cs && !p_any) t_csf = cyc;
    if (!any_cs && p_any) t_csr = cyc;
    if (sclk && !p_sclk) begin
      mon_mosi = {mon_mosi[30:0], mosi};
      mon_bits = mon_bits + 1;
      if (wait_first) begin t_rise = cyc; wait_first = 1'b0; end
    end
    if (!sclk && p_sclk) begin t_fall = cyc; fall_cnt = fall_cnt + 1; end
    cs_seen = cs_seen | ~cs_n;
    if (irq) irq_cnt = irq_cnt + 1;
    p_any = any_cs; p_sclk = sclk;
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  function automatic logic [31:0] topbits(input logic [31:0] w, input int n);
    return (n == 32) ? w : (w >> (32 - n));
  endfunction

  task automatic run_xfer(input int dev, input int n, input logic [31:0] tx,
                          input bit dup, input logic [31:0] sw,
                          input logic [NCS-1:0] exp_cs, input bit mwr,
                          input bit mdup, input bit poke);
    logic [15:0] st, rh, rl;
    int irq0;
    slave_word = sw;
    xfer_id++;
    irq0 = irq_cnt;
    bus_write(3'd4, tx[31:16]);
    bus_write(3'd5, tx[15:0]);
    bus_write(3'd2, {6'd0, dup, !dup, 3'(dev), 5'(n - 1)});
    if (poke) begin
      repeat (6) @(negedge clk);
      // R7: a second command in the busy window, different in every field
      bus_write(3'd2, {6'd0, !dup, dup, 3'((dev + 1) % NCS), 5'((n + 7) % 32)});
    end
    st = 16'h0;
    for (int k = 0; k < 3000 && st[0] == 1'b0; k++) bus_read(3'd3, st);
    repeat (2) @(negedge clk);
    chk("R6", "write-end flag", 32'(st[0]), 32'd1);
    chk("R6", "read-end flag", 32'(st[1]), 32'(dup));
    chk("R2", "sclk rising edges", mon_bits, n);
    chk("R2", "mosi bits", mon_mosi, topbits(tx, n));
    chk("R4", "chip selects seen", 32'(cs_seen), 32'(exp_cs));
    if (exp_cs != 0) begin
      chk("R10", "cs fall to first rise", t_rise - t_csf, HALF);
      chk("R10", "last fall to cs rise", t_csr - t_fall, HALF);
    end
    chk("R8", "irq pulses", irq_cnt - irq0, (dup ? !mdup : !mwr) ? 1 : 0);
    if (dup) begin
      bus_read(3'd6, rh);
      bus_read(3'd7, rl);
      chk("R5", "receive word", {rh, rl}, topbits(sw, n));
    end
    if (poke) begin
      repeat (200) @(negedge clk);
      bus_read(3'd3, st);
      chk("R7", "no second transfer", 32'(st), 32'd0);
      chk("R7", "bit count unchanged", mon_bits, n);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL R2 watchdog: actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    int unsigned seed;
    seed = 32'd20240611;
    void'($urandom(seed));
    bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    bus_read(3'd0, rd); chk("R1", "setup reg", 32'(rd), 32'h0);
    bus_read(3'd1, rd); chk("R1", "select-enable reg", 32'(rd), 32'h1);
    bus_read(3'd3, rd); chk("R1", "status reg", 32'(rd), 32'h0);
    chk("R1", "cs_n", 32'(cs_n), 32'(5'h1F));
    chk("R1", "sclk", 32'(sclk), 32'd0);
    chk("R1", "irq", 32'(irq), 32'd0);

    // R9: clock disabled, command ignored
    slave_word = 32'hFFFF_FFFF; xfer_id++;
    bus_write(3'd4, 16'hA5A5);
    bus_write(3'd2, {6'd0, 2'b10, 3'd0, 5'd7});
    repeat (100) @(negedge clk);
    bus_read(3'd3, rd); chk("R9", "status with clock off", 32'(rd), 32'h0);
    chk("R9", "sclk edges with clock off", mon_bits, 0);
    chk("R9", "cs with clock off", 32'(cs_seen), 32'h0);

    bus_write(3'd0, 16'h0001);
    bus_write(3'd1, 16'h001F);

    // R4: device index beyond range ignored
    xfer_id++;
    bus_write(3'd2, {6'd0, 2'b01, 3'd5, 5'd3});
    repeat (60) @(negedge clk);
    bus_read(3'd3, rd); chk("R4", "status after bad index", 32'(rd), 32'h0);
    chk("R4", "cs after bad index", 32'(cs_seen), 32'h0);

    // directed corners: length 1 and 32, both modes
    run_xfer(0, 1, 32'h8000_0000, 1'b1, 32'h8000_0000, 5'b00001, 0, 0, 0);
    run_xfer(4, 32, 32'hDEAD_BEEF, 1'b1, 32'h1234_5678, 5'b10000, 0, 0, 0);
    run_xfer(2, 32, 32'h0F0F_00FF, 1'b0, 32'h0, 5'b00100, 0, 0, 0);
    run_xfer(3, 9, 32'hFF80_0000, 1'b1, 32'h5500_0000, 5'b01000, 0, 0, 0);

    // R8 masks
    bus_write(3'd0, 16'h0003);
    run_xfer(1, 8, 32'hC300_0000, 1'b0, 32'h0, 5'b00010, 1, 0, 0);
    run_xfer(1, 8, 32'hC300_0000, 1'b1, 32'hA500_0000, 5'b00010, 1, 0, 0);
    bus_write(3'd0, 16'h0005);
    run_xfer(1, 16, 32'h1234_0000, 1'b1, 32'h8001_0000, 5'b00010, 0, 1, 0);
    bus_write(3'd0, 16'h0001);

    // R4: select line disabled, transfer still runs
    bus_write(3'd1, 16'h001B);
    run_xfer(2, 12, 32'hABC0_0000, 1'b1, 32'h7770_0000, 5'b00000, 0, 0, 0);
    bus_write(3'd1, 16'h001F);

    // R7: command during busy ignored
    run_xfer(3, 20, 32'h9876_5000, 1'b0, 32'h0, 5'b01000, 0, 0, 1);

    // R6: read clears, new start clears
    run_xfer(0, 4, 32'hA000_0000, 1'b1, 32'hF000_0000, 5'b00001, 0, 0, 0);
    bus_read(3'd3, rd); chk("R6", "status after read clear", 32'(rd), 32'h0);
    xfer_id++;
    bus_write(3'd2, {6'd0, 2'b10, 3'd1, 5'd2});
    repeat (80) @(negedge clk);
    xfer_id++;
    bus_write(3'd2, {6'd0, 2'b01, 3'd1, 5'd31});
    bus_read(3'd3, rd); chk("R6", "status cleared by new start", 32'(rd), 32'h0);
    for (int k = 0; k < 3000 && rd[0] == 1'b0; k++) bus_read(3'd3, rd);
    chk("R6", "write-only leaves read-end low", 32'(rd), 32'h1);

    // random mix
    for (int i = 0; i < 30; i++) begin
      int dv, nb;
      bit dp, mw, md;
      logic [31:0] tx, sw;
      dv = int'($urandom % NCS);
      nb = int'($urandom % 32) + 1;
      dp = 1'($urandom); mw = 1'($urandom); md = 1'($urandom);
      tx = $urandom; sw = $urandom;
      tx = (nb == 32) ? tx : (tx << (32 - nb));
      bus_write(3'd0, {13'd0, md, mw, 1'b1});
      run_xfer(dv, nb, tx, dp, sw, NCS'(1 << dv), mw, md, 0);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule